// File: doc/BRIEF.md
# Serial DAC Register Control Interface

This block is the digital front end of a serial-input voltage DAC. A host writes 16-bit words MSB first over a three-wire port (serial clock, active-low frame select, serial data). At the end of each complete word the data field passes into a hold register and then into the DAC register. The transfer to the DAC register is either synchronous, at the end of the frame, or deferred until an active-low load strobe is driven low. Which of the two applies is decided per frame by the level of the load strobe when the frame opens.

An active-low clear input forces the output into its clear condition without touching any register. The output comes back from the unchanged DAC register once clear is released and the load strobe is low. An active-low readback enable copies the DAC register into the shift register, and the serial output then streams it out. When readback is idle, the serial output repeats the input stream 16 clocks late, so parts can be daisy-chained. A power-down input raises a low-power flag.

All pins are slow compared with the system clock. Each pin passes through a two-flop synchronizer, and its edges are found on the synchronized copy.

Top module: `sdac_ctrl`

## Requirements
- R1: A frame opens on a falling edge of the frame select. While the frame select stays low, each falling serial-clock edge shifts the data pin into the word, MSB first. At least 16 such edges make the word complete.
- R2: If the load strobe is low when the frame opens, a complete frame loads the DAC register when the frame select rises.
- R3: If the load strobe is high when the frame opens, the rise of the frame select leaves the DAC register unchanged. The held word is loaded once the load strobe is later driven low.
- R4: With DATA_W=14 the code is word bits 13..0. With DATA_W=12 the code is word bits 13..2. Bits 15..14, and for 12 bits also bits 1..0, have no effect.
- R5: If the frame select rises after fewer than 16 falling clock edges, the frame is dropped and the DAC register keeps its value.
- R6: A falling edge on the clear input sets out_clr_o and leaves the DAC register and the readback value unchanged.
- R7: out_clr_o stays high until the clear input is high and the load strobe is low. With the load strobe held low, releasing clear ends it at once. Otherwise it ends at the next low level of the load strobe.
- R8: With readback enable low, the first falling clock edge copies the DAC register into the shift register as {2'b00, code} (12 bits: {2'b00, code, 2'b00}). The serial output then shows word bit 15 and moves one bit lower on each later falling edge.
- R9: Outside readback, the serial output shows word bit 15 of the shift register, so a written bit appears there 16 falling edges after it entered. The output changes only after a falling clock edge.
- R10: pd_o follows the power-down pin and leaves the DAC register unchanged.
- R11: After reset, the DAC code is 0, out_clr_o is low, pd_o is low and the serial output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, data taken on falling edges |
| sync_ni | input | 1 | Frame select, active low |
| sdin_i | input | 1 | Serial data in |
| ldac_ni | input | 1 | Load strobe, active low |
| clr_ni | input | 1 | Output clear, active low |
| rben_ni | input | 1 | Readback enable, active low |
| pd_i | input | 1 | Power-down request |
| sdo_o | output | 1 | Serial data out (readback or chain) |
| dac_code_o | output | DATA_W | DAC register contents |
| out_clr_o | output | 1 | Output is forced to its clear condition |
| pd_o | output | 1 | Low-power flag |

## Verification
The bench builds two copies of the block on the same pins, one with DATA_W=14 and one with DATA_W=12. A single stimulus stream therefore checks both placements of the data field. It also checks that the low two bits are ignored in the narrow variant and that both variants return zero padding on readback. Words are chosen with the don't-care bits set, so a wrong field offset shows as a wrong code. A 32-edge frame exercises the chain path, where the first word must reappear on the serial output while the second word is being shifted in.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned PIN_N  = 7;
  // synchronized pin vector layout
  parameter int unsigned P_SCLK = 0;
  parameter int unsigned P_SYNC = 1;
  parameter int unsigned P_LDAC = 2;
  parameter int unsigned P_CLR  = 3;
  parameter int unsigned P_RBEN = 4;
  parameter int unsigned P_SDIN = 5;
  parameter int unsigned P_PD   = 6;
  parameter logic [PIN_N-1:0] PIN_RST = 7'b001_1111;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_fall_i,
  input  logic  sync_fall_i,
  input  logic  sync_rise_i,
  input  logic  rben_i,
  input  logic  rben_fall_i,
  input  logic  sdin_i,
  input  word_t rb_word_i,
  output word_t word_o,
  output logic  full_o,
  output logic  sdo_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  word_t            sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q, rb_pend_q;
  logic             rb_copy;

  assign rb_copy = sclk_fall_i && rb_pend_q && !rben_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '1;
      cnt_q     <= '0;
      act_q     <= 1'b0;
      rb_pend_q <= 1'b0;
    end else begin
      if (sync_fall_i) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end else if (sync_rise_i) begin
        act_q <= 1'b0;
      end else if (sclk_fall_i && act_q && cnt_q != CNT_W'(WORD_W)) begin
        cnt_q <= cnt_q + 1'b1;
      end

      if (rben_fall_i)  rb_pend_q <= 1'b1;
      else if (rb_copy) rb_pend_q <= 1'b0;
      else if (rben_i)  rb_pend_q <= 1'b0;

      if (rb_copy) sr_q <= rb_word_i;
      else if (sclk_fall_i && (act_q || !rben_i)) sr_q <= {sr_q[WORD_W-2:0], sdin_i};
    end
  end

  assign word_o = sr_q;
  assign full_o = (cnt_q == CNT_W'(WORD_W));
  assign sdo_o  = sr_q[WORD_W-1];

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W));
  a_r9_sdo_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall_i |=> $stable(sdo_o));
  a_r8_copy_msb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_copy |=> !sdo_o);
endmodule

// File: rtl/sdac_load.sv
module sdac_load
  import sdac_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_fall_i,
  input  logic              sync_rise_i,
  input  logic              full_i,
  input  word_t             word_i,
  input  logic              ldac_i,
  input  logic              clr_i,
  input  logic              clr_fall_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              out_clr_o
);
  localparam int unsigned FIELD_MSB = WORD_W - 3;

  logic [DATA_W-1:0] dac_q, hold_q, field;
  logic              mode_sync_q, pend_q, out_clr_q;

  assign field = word_i[FIELD_MSB -: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q       <= '0;
      hold_q      <= '0;
      mode_sync_q <= 1'b1;
      pend_q      <= 1'b0;
      out_clr_q   <= 1'b0;
    end else begin
      if (sync_fall_i) mode_sync_q <= !ldac_i;

      if (sync_rise_i && full_i) begin
        hold_q <= field;
        if (mode_sync_q) begin
          dac_q  <= field;
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
        end
      end else if (pend_q && !ldac_i) begin
        dac_q  <= hold_q;
        pend_q <= 1'b0;
      end

      if (clr_fall_i) out_clr_q <= 1'b1;
      else if (out_clr_q && clr_i && !ldac_i) out_clr_q <= 1'b0;
    end
  end

  assign dac_o     = dac_q;
  assign out_clr_o = out_clr_q;

  a_r6_clr_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_fall_i |=> out_clr_q);
  a_r5_abort_keeps_dac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_rise_i && !full_i && !pend_q) |=> $stable(dac_q));
  a_r3_async_defers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_rise_i && full_i && !mode_sync_q) |=> $stable(dac_q));
  a_r7_flag_held_low_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_clr_q && !clr_i) |=> out_clr_q);
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sync_ni,
  input  logic              sdin_i,
  input  logic              ldac_ni,
  input  logic              clr_ni,
  input  logic              rben_ni,
  input  logic              pd_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              out_clr_o,
  output logic              pd_o
);
  localparam int unsigned PAD_W = WORD_W - 2 - DATA_W;

  logic [PIN_N-1:0] pin_raw, pin_s, pin_d;
  logic sclk_fall, sync_fall, sync_rise, clr_fall, rben_fall, full;
  word_t word, rb_word;

  assign pin_raw[P_SCLK] = sclk_i;
  assign pin_raw[P_SYNC] = sync_ni;
  assign pin_raw[P_LDAC] = ldac_ni;
  assign pin_raw[P_CLR]  = clr_ni;
  assign pin_raw[P_RBEN] = rben_ni;
  assign pin_raw[P_SDIN] = sdin_i;
  assign pin_raw[P_PD]   = pd_i;

  sdac_sync #(.N(PIN_N), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_d <= PIN_RST;
    else         pin_d <= pin_s;
  end

  assign sclk_fall = pin_d[P_SCLK] & ~pin_s[P_SCLK];
  assign sync_fall = pin_d[P_SYNC] & ~pin_s[P_SYNC];
  assign sync_rise = ~pin_d[P_SYNC] & pin_s[P_SYNC];
  assign clr_fall  = pin_d[P_CLR] & ~pin_s[P_CLR];
  assign rben_fall = pin_d[P_RBEN] & ~pin_s[P_RBEN];

  if (PAD_W == 0) begin : g_rb_full
    assign rb_word = {2'b00, dac_code_o};
  end else begin : g_rb_pad
    assign rb_word = {2'b00, dac_code_o, {PAD_W{1'b0}}};
  end

  sdac_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_fall_i(sclk_fall),
    .sync_fall_i(sync_fall),
    .sync_rise_i(sync_rise),
    .rben_i     (pin_s[P_RBEN]),
    .rben_fall_i(rben_fall),
    .sdin_i     (pin_s[P_SDIN]),
    .rb_word_i  (rb_word),
    .word_o     (word),
    .full_o     (full),
    .sdo_o      (sdo_o)
  );

  sdac_load #(.DATA_W(DATA_W)) u_load (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_fall_i(sync_fall),
    .sync_rise_i(sync_rise),
    .full_i     (full),
    .word_i     (word),
    .ldac_i     (pin_s[P_LDAC]),
    .clr_i      (pin_s[P_CLR]),
    .clr_fall_i (clr_fall),
    .dac_o      (dac_code_o),
    .out_clr_o  (out_clr_o)
  );

  assign pd_o = pin_s[P_PD];

  a_r10_pd_keeps_dac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_s[P_PD] != pin_d[P_PD] && !sync_rise && pin_s[P_LDAC]) |=> $stable(dac_code_o));
endmodule

// File: tb/sdac_ctrl_tb.sv
module sdac_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int PH    = 4 * CLK_P;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b0;
  logic clr_n = 1'b1, rben_n = 1'b1, pd = 1'b0;
  logic sdo14, sdo12, clr14, clr12, pd14, pd12;
  logic [13:0] dac14;
  logic [11:0] dac12;

  int n_chk = 0, n_bad = 0;
  logic [13:0] exp_q[$];
  logic [13:0] mon_last = '0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sdac_ctrl #(.DATA_W(14)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sync_ni(sync_n), .sdin_i(sdin),
    .ldac_ni(ldac_n), .clr_ni(clr_n), .rben_ni(rben_n), .pd_i(pd),
    .sdo_o(sdo14), .dac_code_o(dac14), .out_clr_o(clr14), .pd_o(pd14));

  sdac_ctrl #(.DATA_W(12)) u_dut_n12 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sync_ni(sync_n), .sdin_i(sdin),
    .ldac_ni(ldac_n), .clr_ni(clr_n), .rben_ni(rben_n), .pd_i(pd),
    .sdo_o(sdo12), .dac_code_o(dac12), .out_clr_o(clr12), .pd_o(pd12));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every change of the 14-bit code must match the next expected item
  always @(negedge clk) begin
    if (rst_n && !done && dac14 !== mon_last) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2/R3/R5 unexpected update actual=%h expected=%h", dac14, mon_last);
      end else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        if (dac14 !== e) begin
          n_bad++;
          $display("FAIL R2/R3 code actual=%h expected=%h", dac14, e);
        end
      end
      mon_last = dac14;
    end
  end

  task automatic clk_bit(input logic b);
    sdin = b;
    #PH sclk = 1'b0;
    #PH sclk = 1'b1;
  endtask

  task automatic sync_lo(); sync_n = 1'b0; #PH; endtask
  task automatic sync_hi(); #PH sync_n = 1'b1; #(2*PH); endtask

  task automatic frame(input logic [15:0] w, input int nbits);
    sync_lo();
    for (int i = 0; i < nbits; i++) clk_bit(w[15-i]);
    sync_hi();
  endtask

  task automatic readback(input logic [15:0] e14, input logic [15:0] e12, input string req);
    logic [15:0] g14, g12;
    rben_n = 1'b0;
    #PH;
    clk_bit(1'b0);
    for (int i = 0; i < 16; i++) begin
      g14[15-i] = sdo14;
      g12[15-i] = sdo12;
      if (i < 15) clk_bit(1'b0);
    end
    rben_n = 1'b1;
    #PH;
    chk({req, " readback w14"}, 32'(g14), 32'(e14));
    chk({req, " readback w12"}, 32'(g12), 32'(e12));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] a, b, g14, g12;
    #(3*CLK_P) rst_n = 1'b1;
    #(6*CLK_P);
    // R11 reset state
    chk("R11 code14", 32'(dac14), 0);
    chk("R11 code12", 32'(dac12), 0);
    chk("R11 clr", 32'(clr14), 0);
    chk("R11 sdo", 32'({sdo14, sdo12}), 32'b11);
    chk("R11 pd", 32'(pd14), 0);

    // R1 R2 R4: synchronous update, don't-care bits set
    exp_q.push_back(14'h35A7);
    frame(16'hF5A7, 16);
    chk("R2 R4 code12", 32'(dac12), 32'h0D69);

    // R3: deferred update
    ldac_n = 1'b1;
    #PH;
    frame(16'h0C3D, 16);
    #(2*PH);
    chk("R3 held w12", 32'(dac12), 32'h0D69);
    exp_q.push_back(14'h0C3D);
    ldac_n = 1'b0;
    #(2*PH);
    chk("R3 loaded w12", 32'(dac12), 32'h030F);

    // R5: short frame dropped
    frame(16'hFFFF, 10);
    #(2*PH);
    chk("R5 abort w14", 32'(dac14), 32'h0C3D);
    chk("R5 abort w12", 32'(dac12), 32'h030F);

    // R4 another pattern
    exp_q.push_back(14'h2AAA);
    frame(16'h2AAA, 16);
    chk("R4 code12", 32'(dac12), 32'h0AAA);

    // R6 R7: clear with strobe high, resume on strobe
    ldac_n = 1'b1;
    #PH clr_n = 1'b0;
    #(2*PH);
    chk("R6 flag set", 32'({clr14, clr12}), 32'b11);
    readback(16'h2AAA, 16'h2AA8, "R6");
    chk("R6 code kept", 32'(dac14), 32'h2AAA);
    clr_n = 1'b1;
    #(2*PH);
    chk("R7 flag held", 32'(clr14), 1);
    ldac_n = 1'b0;
    #(2*PH);
    chk("R7 flag ends on strobe", 32'(clr14), 0);
    // R7: strobe low, auto resume
    clr_n = 1'b0;
    #(2*PH);
    chk("R7 flag set again", 32'(clr12), 1);
    clr_n = 1'b1;
    #(2*PH);
    chk("R7 auto resume", 32'({clr14, clr12}), 0);

    // R8 readback after new code
    exp_q.push_back(14'h1B2C);
    frame(16'hDB2C, 16);
    readback(16'h1B2C, 16'h1B2C, "R8");

    // R10 power-down
    pd = 1'b1;
    #(2*PH);
    chk("R10 pd set", 32'({pd14, pd12}), 32'b11);
    chk("R10 code kept", 32'(dac14), 32'h1B2C);
    pd = 1'b0;
    #(2*PH);
    chk("R10 pd clear", 32'(pd12), 0);

    // R9 daisy chain: 32-edge frame
    a = 16'h8E71;
    b = 16'h3456;
    exp_q.push_back(14'h3456);
    sync_lo();
    for (int i = 0; i < 16; i++) clk_bit(a[15-i]);
    for (int i = 0; i < 16; i++) begin
      g14[15-i] = sdo14;
      g12[15-i] = sdo12;
      clk_bit(b[15-i]);
    end
    sync_hi();
    chk("R9 chain w14", 32'(g14), 32'(a));
    chk("R9 chain w12", 32'(g12), 32'(a));
    chk("R9 tail code12", 32'(dac12), 32'h0D15);

    #(2*PH);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule